// File: doc/BRIEF.md
# Configuration Memory Scrubber

The scrubber keeps a frame-organised configuration memory in step with a golden copy while the user logic goes on running. A pass visits every frame in turn. It reads the frame back one word at a time and compares each word with the word at the same address in the golden store. Only when at least one word of the frame differs does it rewrite that frame, word by word, from the golden store. It never drives a reset of any kind toward the logic the memory configures.

A pass starts on a `start` pulse, or when a programmable idle interval runs out, so that `period` sets an upper bound on how long an upset can remain in place. When the number of damaged frames in one pass reaches a threshold, the damage is treated as a mass erasure rather than as scattered upsets. The scrubber then stops repairing, ends the pass, and raises an interrupt flag together with a request for a full reload. Both stay up until the reload is acknowledged. Damage that readback cannot observe is outside the reach of this block.

Each pass counts damaged frames and damaged words. Both counts saturate, and both are published when the pass ends.

Top module: `cfg_scrubber`

States: IDLE (waiting; the interval timer runs), CMP_RD (read a word of the memory and of the golden store), CMP_CHK (compare), DECIDE (clean frame, repair, or erasure), REP_RD (read a golden word), REP_WR (write it back), NEXT (advance the frame), FINISH (publish the counts, pulse `done`). Transitions:
- IDLE→CMP_RD on launch.
- CMP_RD→CMP_CHK always.
- CMP_CHK→CMP_RD while words remain in the frame, and CMP_CHK→DECIDE after the last word.
- DECIDE→NEXT if the frame is clean.
- DECIDE→REP_RD if the frame is damaged and below the threshold.
- DECIDE→FINISH if the frame is damaged and the threshold is reached.
- REP_RD→REP_WR always.
- REP_WR→REP_RD while words remain, and REP_WR→NEXT after the last word.
- NEXT→CMP_RD while frames remain, and NEXT→FINISH after the last frame.
- FINISH→IDLE always.

## Requirements
- R1: After reset, `busy`, `done`, `cfg_rd_en`, `cfg_wr_en`, `sefi`, `reconfig_req` and both published counts are 0. No strobe is ever asserted outside a pass.
- R2: When `start` is high in IDLE and `sefi` is low, a pass begins on the next cycle. `busy` then stays high until `done`, `done` is high for exactly one cycle of the pass, and a `start` received during a pass has no effect.
- R3: With `period`=P≠0, a new pass begins after exactly P consecutive idle cycles. With P=0, no pass begins without `start`.
- R4: Words are addressed as `frame*FRAME_WORDS+word` and are visited frame 0 first and word 0 first. Both memories answer one cycle after the address, and `cfg_rd_en` and `cfg_wr_en` are never high in the same cycle.
- R5: A frame with at least one differing word is rewritten in full (FRAME_WORDS writes) from the golden store, at the address just read from that store. A clean frame is never written, so after a pass without erasure the memory matches the golden copy.
- R6: At the end of a pass, `bad_frames` and `bad_words` hold that pass's counts of damaged frames and damaged words, each saturating at 2^CNT_W-1. They change at no other time.
- R7: When a damaged frame brings the pass's damaged-frame count to SEFI_FRAMES, that frame and all later frames are left unwritten and the pass ends at once. `sefi` and `reconfig_req` then rise and stay high until `reconfig_ack`, and no pass starts while they are high.
- R8: A pass lasts N_FRAMES*(2*FRAME_WORDS+2)+1 cycles plus 2*FRAME_WORDS cycles per repaired frame. When a pass ends on erasure, its length is cut at the frame that triggered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one pass |
| period | input | PERIOD_W | Idle cycles between automatic passes; 0 turns them off |
| reconfig_ack | input | 1 | Full reload done; clears the interrupt flag |
| cfg_rd_en | output | 1 | Configuration memory read strobe |
| cfg_wr_en | output | 1 | Configuration memory write strobe |
| cfg_addr | output | ADDR_W | Configuration memory word address |
| cfg_wdata | output | DATA_W | Write data |
| cfg_rdata | input | DATA_W | Read data, one cycle after the read |
| gold_addr | output | ADDR_W | Golden store word address |
| gold_rdata | input | DATA_W | Golden data, one cycle after the address |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| bad_frames | output | CNT_W | Damaged frames in the last pass |
| bad_words | output | CNT_W | Damaged words in the last pass |
| sefi | output | 1 | Mass-erasure interrupt flag |
| reconfig_req | output | 1 | Full reload request |

## Verification
The bench builds the block with 8 frames of 4 words, CNT_W=3 and SEFI_FRAMES=5. With CNT_W=3, eight damaged words in one pass are enough to show the word count saturating at 7. With a threshold of 5, a full erasure trips the interrupt after four frames have been repaired, which also shows that the trigger frame and later frames are left alone. An 8-bit `period` keeps the interval test short: it measures an idle gap of exactly 12 cycles and then shows that a period of zero stops the automatic passes.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMP_RD,
        S_CMP_CHK,
        S_DECIDE,
        S_REP_RD,
        S_REP_WR,
        S_NEXT,
        S_FINISH
    } scrub_state_e;
endpackage

// File: rtl/scrub_period_timer.sv
module scrub_period_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [PERIOD_W-1:0] period,
    output logic                hit
);
    logic [PERIOD_W-1:0] cnt_q;

    // Fires once the idle run reaches period cycles; zero period never fires.
    assign hit = en && (period != '0) && (cnt_q >= period - PERIOD_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!en || hit)     cnt_q <= '0;
        else if (cnt_q != '1)    cnt_q <= cnt_q + PERIOD_W'(1);
    end
endmodule

// File: rtl/scrub_sat_cnt.sv
module scrub_sat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q <= '0;
        else if (clr)               q <= '0;
        else if (inc && q != '1)    q <= q + CNT_W'(1);
    end
endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber
    import scrub_pkg::*;
#(
    parameter int N_FRAMES    = 16,
    parameter int FRAME_WORDS = 8,
    parameter int DATA_W      = 32,
    parameter int PERIOD_W    = 16,
    parameter int CNT_W       = 8,
    parameter int SEFI_FRAMES = 8,
    localparam int ADDR_W     = $clog2(N_FRAMES * FRAME_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PERIOD_W-1:0] period,
    input  logic                reconfig_ack,
    output logic                cfg_rd_en,
    output logic                cfg_wr_en,
    output logic [ADDR_W-1:0]   cfg_addr,
    output logic [DATA_W-1:0]   cfg_wdata,
    input  logic [DATA_W-1:0]   cfg_rdata,
    output logic [ADDR_W-1:0]   gold_addr,
    input  logic [DATA_W-1:0]   gold_rdata,
    output logic                busy,
    output logic                done,
    output logic [CNT_W-1:0]    bad_frames,
    output logic [CNT_W-1:0]    bad_words,
    output logic                sefi,
    output logic                reconfig_req
);
    localparam int FRM_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1;
    localparam int WRD_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

    scrub_state_e         state_q, state_d;
    logic [FRM_W-1:0]     frame_q;
    logic [WRD_W-1:0]     word_q;
    logic                 frame_bad_q;
    logic                 sefi_q;
    logic [CNT_W-1:0]     pub_frames_q, pub_words_q;
    logic [CNT_W-1:0]     run_frames, run_words;
    logic                 timer_hit, launch, mismatch, last_word, last_frame, sefi_hit;

    assign mismatch   = (cfg_rdata != gold_rdata);
    assign last_word  = (word_q == WRD_W'(FRAME_WORDS - 1));
    assign last_frame = (frame_q == FRM_W'(N_FRAMES - 1));
    assign sefi_hit   = ({1'b0, run_frames} + (CNT_W+1)'(1)) >= (CNT_W+1)'(SEFI_FRAMES);
    assign launch     = (state_q == S_IDLE) && !sefi_q && (start || timer_hit);

    scrub_period_timer #(.PERIOD_W(PERIOD_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     ((state_q == S_IDLE) && !sefi_q),
        .period (period),
        .hit    (timer_hit)
    );

    scrub_sat_cnt #(.CNT_W(CNT_W)) i_word_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .inc   ((state_q == S_CMP_CHK) && mismatch),
        .q     (run_words)
    );

    scrub_sat_cnt #(.CNT_W(CNT_W)) i_frame_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .inc   ((state_q == S_DECIDE) && frame_bad_q),
        .q     (run_frames)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (launch) state_d = S_CMP_RD;
            S_CMP_RD:  state_d = S_CMP_CHK;
            S_CMP_CHK: state_d = last_word ? S_DECIDE : S_CMP_RD;
            S_DECIDE: begin
                if (!frame_bad_q)  state_d = S_NEXT;
                else if (sefi_hit) state_d = S_FINISH;
                else               state_d = S_REP_RD;
            end
            S_REP_RD:  state_d = S_REP_WR;
            S_REP_WR:  state_d = last_word ? S_NEXT : S_REP_RD;
            S_NEXT:    state_d = last_frame ? S_FINISH : S_CMP_RD;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register and pass bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            frame_q      <= '0;
            word_q       <= '0;
            frame_bad_q  <= 1'b0;
            sefi_q       <= 1'b0;
            pub_frames_q <= '0;
            pub_words_q  <= '0;
        end else begin
            state_q <= state_d;
            if (reconfig_ack) sefi_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (launch) begin
                    frame_q     <= '0;
                    word_q      <= '0;
                    frame_bad_q <= 1'b0;
                end
                S_CMP_CHK: begin
                    if (mismatch)   frame_bad_q <= 1'b1;
                    if (!last_word) word_q <= word_q + WRD_W'(1);
                end
                S_DECIDE: begin
                    word_q <= '0;
                    if (frame_bad_q && sefi_hit) sefi_q <= 1'b1;
                end
                S_REP_WR: if (!last_word) word_q <= word_q + WRD_W'(1);
                S_NEXT: begin
                    if (!last_frame) frame_q <= frame_q + FRM_W'(1);
                    word_q      <= '0;
                    frame_bad_q <= 1'b0;
                end
                S_FINISH: begin
                    pub_frames_q <= run_frames;
                    pub_words_q  <= run_words;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cfg_addr  = ADDR_W'(frame_q) * ADDR_W'(FRAME_WORDS) + ADDR_W'(word_q);
        gold_addr = cfg_addr;
        cfg_wdata = gold_rdata;
        cfg_rd_en = (state_q == S_CMP_RD);
        cfg_wr_en = (state_q == S_REP_WR);
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
    end

    assign bad_frames   = pub_frames_q;
    assign bad_words    = pub_words_q;
    assign sefi         = sefi_q;
    assign reconfig_req = sefi_q;
endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reconfig_ack,
    input logic              cfg_rd_en,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [ADDR_W-1:0] gold_addr,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  bad_frames,
    input logic [CNT_W-1:0]  bad_words,
    input logic              sefi
);
    assert_no_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cfg_rd_en && !cfg_wr_en));

    assert_done_in_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_rd_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rd_en && cfg_wr_en));

    assert_wr_from_gold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |-> (cfg_addr == $past(gold_addr)));

    assert_counts_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(bad_frames) && $stable(bad_words)));

    assert_sefi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sefi && !reconfig_ack) |=> sefi);

    assert_sefi_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sefi) |=> !busy);
endmodule

bind cfg_scrubber scrub_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_scrub_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reconfig_ack (reconfig_ack),
    .cfg_rd_en    (cfg_rd_en),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_addr     (cfg_addr),
    .gold_addr    (gold_addr),
    .busy         (busy),
    .done         (done),
    .bad_frames   (bad_frames),
    .bad_words    (bad_words),
    .sefi         (sefi)
);

// File: tb/test_cfg_scrubber.sv
`timescale 1ns/1ps
module test_cfg_scrubber;
    localparam int NF = 8, FW = 4, DW = 16, PW = 8, CW = 3, SF = 5;
    localparam int NW = NF * FW;
    localparam int AW = $clog2(NW);
    localparam int SAT = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, reconfig_ack = 1'b0;
    logic [PW-1:0] period = '0;
    logic cfg_rd_en, cfg_wr_en, busy, done, sefi, reconfig_req;
    logic [AW-1:0] cfg_addr, gold_addr;
    logic [DW-1:0] cfg_wdata, cfg_rdata, gold_rdata;
    logic [CW-1:0] bad_frames, bad_words;

    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [DW-1:0] inj_data = '0;
    logic [DW-1:0] cfg_mem [NW];
    int wr_cnt = 0, both_cnt = 0;
    int n_checks = 0, n_errors = 0;
    int exp_cyc, exp_frames, exp_words, exp_writes, exp_resid;
    bit exp_sefi;

    always #4 clk = ~clk;

    cfg_scrubber #(.N_FRAMES(NF), .FRAME_WORDS(FW), .DATA_W(DW), .PERIOD_W(PW),
                   .CNT_W(CW), .SEFI_FRAMES(SF)) i_cfg_scrubber (
        .clk(clk), .rst_n(rst_n), .start(start), .period(period),
        .reconfig_ack(reconfig_ack), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .gold_addr(gold_addr), .gold_rdata(gold_rdata), .busy(busy), .done(done),
        .bad_frames(bad_frames), .bad_words(bad_words), .sefi(sefi),
        .reconfig_req(reconfig_req));

    function automatic logic [DW-1:0] gold_val(int a);
        return DW'(16'hA5C3 ^ (a * 16'h1357));
    endfunction

    // Memory models: one-cycle read latency on both stores
    always @(posedge clk) begin
        if (cfg_rd_en) cfg_rdata <= cfg_mem[cfg_addr];
        if (cfg_wr_en) begin
            cfg_mem[cfg_addr] <= cfg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (inj_en) cfg_mem[inj_addr] <= inj_data;
        if (cfg_rd_en && cfg_wr_en) both_cnt <= both_cnt + 1;
        gold_rdata <= gold_val(int'(gold_addr));
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic inject(int a, logic [DW-1:0] d);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = AW'(a); inj_data = d;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic damage(int a);
        inject(a, gold_val(a) ^ DW'(($urandom % 16'hFFFF) + 1));
    endtask

    function automatic int residual();
        int r = 0;
        for (int a = 0; a < NW; a++) if (cfg_mem[a] != gold_val(a)) r++;
        return r;
    endfunction

    // Expected pass outcome from the requirements (R5..R8)
    function automatic void predict();
        exp_cyc = 0; exp_frames = 0; exp_words = 0; exp_writes = 0; exp_sefi = 0;
        exp_resid = residual();
        for (int f = 0; f < NF; f++) begin
            int nb = 0;
            for (int w = 0; w < FW; w++) if (cfg_mem[f*FW+w] != gold_val(f*FW+w)) nb++;
            exp_cyc += 2*FW + 1;
            exp_words += nb;
            if (nb > 0) begin
                exp_frames++;
                if (exp_frames >= SF) begin exp_sefi = 1; break; end
                exp_cyc += 2*FW; exp_writes += FW; exp_resid -= nb;
            end
            exp_cyc += 1;
        end
        exp_cyc += 1;
    endfunction

    task automatic run_pass(string tag);
        int wr0, cyc, dn, guard;
        predict();
        wr0 = wr_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0; dn = 0; guard = 0;
        while (busy && guard < 2000) begin
            cyc++; guard++;
            if (done) dn++;
            if (cyc == 3) start = 1'b1;   // start during a pass: no effect (R2)
            if (cyc == 4) start = 1'b0;
            @(negedge clk);
        end
        $display("pass %s: cycles=%0d", tag, cyc);
        chk(cyc == exp_cyc, "R8", {tag, " pass length"}, cyc, exp_cyc);
        chk(dn == 1, "R2", {tag, " done pulses"}, dn, 1);
        chk(int'(bad_frames) == ((exp_frames > SAT) ? SAT : exp_frames), "R6",
            {tag, " bad_frames"}, bad_frames, (exp_frames > SAT) ? SAT : exp_frames);
        chk(int'(bad_words) == ((exp_words > SAT) ? SAT : exp_words), "R6",
            {tag, " bad_words"}, bad_words, (exp_words > SAT) ? SAT : exp_words);
        chk(sefi == exp_sefi && reconfig_req == exp_sefi, "R7", {tag, " sefi flag"},
            sefi, exp_sefi);
        chk(wr_cnt - wr0 == exp_writes, "R5", {tag, " writes"}, wr_cnt - wr0, exp_writes);
        chk(residual() == exp_resid, "R5", {tag, " residual damage"}, residual(), exp_resid);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        int gap, guard;
        void'($urandom(32'd2024));
        for (int a = 0; a < NW; a++) begin
            @(negedge clk);
            inj_en = 1'b1; inj_addr = AW'(a); inj_data = gold_val(a);
        end
        @(negedge clk) inj_en = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !cfg_rd_en && !cfg_wr_en, "R1", "idle after reset", busy, 0);
        chk(bad_frames == 0 && bad_words == 0, "R1", "counts after reset", bad_words, 0);
        chk(!sefi && !reconfig_req, "R1", "flag after reset", sefi, 0);

        run_pass("clean");
        damage(0);            run_pass("first_word");
        damage(NW - 1);       run_pass("last_word");
        for (int it = 0; it < 4; it++) begin
            int n = 1 + ($urandom % 4);
            for (int k = 0; k < n; k++) damage($urandom % NW);
            run_pass("random");
        end
        // R6 saturation: 8 damaged words across 4 frames
        for (int f = 0; f < 4; f++) begin damage(f*FW); damage(f*FW + 1); end
        run_pass("saturate");

        // R7: full erasure
        for (int a = 0; a < NW; a++) damage(a);
        run_pass("erasure");
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        gap = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy) gap++; end
        chk(gap == 0 && sefi, "R7", "start blocked while flagged", gap, 0);
        @(negedge clk) reconfig_ack = 1'b1;
        @(negedge clk) reconfig_ack = 1'b0;
        chk(!sefi && !reconfig_req, "R7", "ack clears flag", sefi, 0);
        run_pass("after_ack");
        chk(residual() == 0, "R5", "memory restored", residual(), 0);

        // R3: periodic launch
        @(negedge clk) period = PW'(12);
        guard = 0;
        while (!busy && guard < 500) begin @(negedge clk); guard++; end
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
        gap = 0;
        while (!busy && guard < 1500) begin gap++; @(negedge clk); guard++; end
        chk(gap == 12, "R3", "idle gap", gap, 12);
        period = '0;
        while (busy && guard < 2000) begin @(negedge clk); guard++; end
        gap = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (busy) gap++; end
        chk(gap == 0, "R3", "zero period stays idle", gap, 0);

        chk(both_cnt == 0, "R4", "read and write together", both_cnt, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule